// File: doc/BRIEF.md
# Packet-Counted SPI Master Shift Engine

This block is the serial engine of an SPI master. Configuration arrives as plain level inputs held by a register front end: a prescaler, clock polarity and phase, a word size, RX and TX channel enables, a high-speed sampling option, a packet-count limit with its enable, a software reset and a select-inactive control. The engine takes transmit words from an external FIFO through a valid/pop pair and delivers received words to another external FIFO through a push strobe. It drives SCLK, MOSI and one active-low select, and samples MISO.

The controller is built around a three-state machine. `ST_IDLE` waits for a word source. `ST_LEAD` covers the first half of each bit and `ST_TRAIL` the second. The transitions are: IDLE to LEAD on a start, where the word is loaded and the TX FIFO popped if TX is on; LEAD to TRAIL on a half-period tick, which is the normal MISO sample point; TRAIL to LEAD on a tick while bits remain, where MOSI shifts; TRAIL to IDLE on the tick of the last bit, where the word is pushed to RX. An abort (select inactive or software reset) sends any state to IDLE. When the packet counter is on, the engine starts exactly N words per select session whether or not TX is on. With TX off and RX on, it sends zero words, so that the clock runs for receive-only transfers.

Top module: `spi_pkt_master`

## Requirements
- R1: After reset, with select inactive and the TX FIFO empty: ss_n is 1, sclk is at the cpol level, rx_push and tx_pop are 0, and tx_done is 1.
- R2: Each half period of SCLK lasts psr+1 clock cycles, so a full SCLK period is 2*(psr+1) cycles.
- R3: While sclk_en is 0, SCLK holds its idle level, no word starts and a word in flight does not advance. Setting sclk_en to 1 lets the transfer run on.
- R4: SCLK idles at cpol. With cpha=0, MOSI is valid at the leading (first) edge of each bit. With cpha=1, it is valid at the trailing (second) edge. Each word gives exactly W leading edges.
- R5: word_sz selects the width W: 0 gives 8 bits, 1 gives 16, and 2 or 3 give 32. The word is sent from tx_data[W-1:0], MSB first, and the bits above W are ignored. The received word appears in rx_data[W-1:0], MSB first, zero-extended.
- R6: MISO is normally sampled at the edge that starts the second half of a bit. When hs_en=1 and cpha=0, it is sampled one half period later, at the end of the bit. hs_en has no effect when cpha=1.
- R7: ss_n follows ss_inact. No word starts while ss_inact is 1. Raising ss_inact during a word aborts it: SCLK returns to idle within one cycle and nothing is pushed.
- R8: When pkt_en=1, at most pkt_cnt words start per select session, and the engine then stays idle. The word count restarts each time the select goes inactive.
- R9: When pkt_en=1, tx_on=0 and rx_on=1, the engine clocks all-zero words, pops nothing and pushes every received word.
- R10: When pkt_en=0, words run only while tx_on=1 and tx_valid=1. A received word is pushed only when rx_on=1.
- R11: While soft_rst is 1, fifo_clr is 1 and the engine aborts to idle without pushing. soft_rst also restarts the word count.
- R12: tx_done is 1 exactly when the engine is idle and tx_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psr | input | PSR_W | Prescaler; half period is psr+1 cycles |
| sclk_en | input | 1 | Enables SCLK generation |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | Phase: 0 samples on the leading edge, 1 on the trailing edge |
| hs_en | input | 1 | Delays the MISO sample by one half period (cpha=0 only) |
| rx_on | input | 1 | RX channel enable |
| tx_on | input | 1 | TX channel enable |
| soft_rst | input | 1 | Software reset: abort and FIFO flush |
| word_sz | input | 2 | Word size code |
| pkt_en | input | 1 | Packet counter enable |
| pkt_cnt | input | CNT_W | Number of words per session |
| ss_inact | input | 1 | 1 drives the select inactive |
| tx_valid | input | 1 | TX FIFO holds a word |
| tx_data | input | DW | Head word of the TX FIFO |
| tx_pop | output | 1 | Consumes the TX FIFO head this cycle |
| rx_push | output | 1 | Writes rx_data into the RX FIFO |
| rx_data | output | DW | Received word |
| fifo_clr | output | 1 | Flush request to both FIFOs |
| tx_done | output | 1 | Engine idle and TX FIFO empty |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
tx_pop is combinational and falls in the same cycle as the start, so the bench counts it at the rising edge. SCLK and MOSI change just after the clock edge that moves the state, and rx_push is registered one cycle after the last half period ends. An abort reaches ss_n at once and SCLK after one edge. The bench drives inputs and samples outputs on falling edges. It waits on its own counters of pushes, pops and SCLK edges instead of fixed cycle counts, then leaves a settling gap before comparing. The half-period check measures every active SCLK level in falling-edge samples against psr+1.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } spi_st_e;
endpackage

// File: rtl/spi_pm_tick.sv
module spi_pm_tick #(
    parameter int PSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSR_W-1:0] psr,
    output logic             tick
);
    logic [PSR_W-1:0] cnt_q;

    assign tick = run && (cnt_q == psr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R2
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/spi_pm_wcount.sv
module spi_pm_wcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             reached
);
    logic [CNT_W-1:0] cnt_q;

    assign reached = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    // R8
    wc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
endmodule

// File: rtl/spi_pkt_master.sv
module spi_pkt_master
    import spi_pm_pkg::*;
#(
    parameter int DW    = 32,
    parameter int PSR_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSR_W-1:0] psr,
    input  logic             sclk_en,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             hs_en,
    input  logic             rx_on,
    input  logic             tx_on,
    input  logic             soft_rst,
    input  logic [1:0]       word_sz,
    input  logic             pkt_en,
    input  logic [CNT_W-1:0] pkt_cnt,
    input  logic             ss_inact,
    input  logic             tx_valid,
    input  logic [DW-1:0]    tx_data,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [DW-1:0]    rx_data,
    output logic             fifo_clr,
    output logic             tx_done,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             ss_n
);
    localparam int IW = $clog2(DW);

    spi_st_e      st_q;
    logic [DW-1:0] tx_sh_q, rx_sh_q, rx_data_q;
    logic [IW-1:0] bit_q;
    logic          rx_push_q;
    logic [IW:0]   wbits;
    logic          abort, src_ok, start, run, tick, reached, hs_eff, last_bit;

    always_comb begin
        unique case (word_sz)
            2'd0:    wbits = (IW+1)'(DW / 4);
            2'd1:    wbits = (IW+1)'(DW / 2);
            default: wbits = (IW+1)'(DW);
        endcase
    end

    assign abort    = soft_rst || ss_inact;
    assign hs_eff   = hs_en && !cpha;
    assign last_bit = (bit_q == '0);
    assign src_ok   = tx_on ? tx_valid : (pkt_en && rx_on);
    assign start    = (st_q == ST_IDLE) && !abort && sclk_en && src_ok
                      && !(pkt_en && reached);
    assign run      = (st_q != ST_IDLE) && sclk_en && !abort;

    spi_pm_tick #(.PSR_W(PSR_W)) i_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .psr(psr), .tick(tick)
    );

    spi_pm_wcount #(.CNT_W(CNT_W)) i_wcount (
        .clk(clk), .rst_n(rst_n), .clr(abort), .inc(start),
        .limit(pkt_cnt), .reached(reached)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else if (abort)
            st_q <= ST_IDLE;
        else begin
            unique case (st_q)
                ST_IDLE:  if (start) st_q <= ST_LEAD;
                ST_LEAD:  if (tick)  st_q <= ST_TRAIL;
                ST_TRAIL: if (tick)  st_q <= last_bit ? ST_IDLE : ST_LEAD;
                default:             st_q <= ST_IDLE;
            endcase
        end
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q   <= '0;
            rx_sh_q   <= '0;
            rx_data_q <= '0;
            bit_q     <= '0;
            rx_push_q <= 1'b0;
        end else begin
            rx_push_q <= 1'b0;
            if (!abort) begin
                unique case (st_q)
                    ST_IDLE: if (start) begin
                        tx_sh_q <= tx_on ? (tx_data << (DW - int'(wbits))) : '0;
                        rx_sh_q <= '0;
                        bit_q   <= IW'(wbits - 1'b1);
                    end
                    ST_LEAD: if (tick && !hs_eff)
                        rx_sh_q <= {rx_sh_q[DW-2:0], miso};
                    ST_TRAIL: if (tick) begin
                        tx_sh_q <= tx_sh_q << 1;
                        bit_q   <= bit_q - 1'b1;
                        if (hs_eff)
                            rx_sh_q <= {rx_sh_q[DW-2:0], miso};
                        if (last_bit) begin
                            rx_push_q <= rx_on;
                            rx_data_q <= hs_eff ? {rx_sh_q[DW-2:0], miso} : rx_sh_q;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign tx_pop   = start && tx_on;
    assign rx_push  = rx_push_q;
    assign rx_data  = rx_data_q;
    assign fifo_clr = soft_rst;
    assign tx_done  = (st_q == ST_IDLE) && !tx_valid;
    assign ss_n     = ss_inact;
    assign mosi     = tx_sh_q[DW-1];
    assign sclk     = !sclk_en              ? cpol :
                      (st_q == ST_LEAD)     ? (cpol ^ cpha) :
                      (st_q == ST_TRAIL)    ? (cpol ^ ~cpha) : cpol;

    // R7
    ss_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_inact |=> st_q == ST_IDLE);
    // R11
    srst_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !rx_push);
    // R3
    clk_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_en && !abort) |=> $stable(st_q));
    // R8
    pkt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && pkt_en && reached) |=> st_q == ST_IDLE);
    // R10
    push_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(rx_on));
endmodule

// File: tb/test_spi_pkt_master.sv
module test_spi_pkt_master;
    localparam logic [63:0] STREAM = 64'hB4E2_7C19_05AF_D368;
    // {cpol, cpha, word_sz[1:0], psr[7:0], hs_en, tx[31:0]}
    localparam logic [44:0] VEC [7] = '{
        {1'b0, 1'b0, 2'd0, 8'd1, 1'b0, 32'hFFFF_FFA5},
        {1'b1, 1'b0, 2'd1, 8'd0, 1'b0, 32'h0000_C3E1},
        {1'b0, 1'b1, 2'd2, 8'd2, 1'b0, 32'h8F0F_1234},
        {1'b1, 1'b1, 2'd0, 8'd3, 1'b0, 32'h0000_005A},
        {1'b0, 1'b0, 2'd2, 8'd0, 1'b1, 32'hDEAD_BEEF},
        {1'b0, 1'b1, 2'd1, 8'd1, 1'b1, 32'h0000_1357},
        {1'b0, 1'b0, 2'd3, 8'd1, 1'b0, 32'h1234_5678}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] c_psr = 8'd1;
    logic c_sclk_en = 1'b1, c_cpol = 1'b0, c_cpha = 1'b0, c_hs = 1'b0;
    logic c_rx_on = 1'b0, c_tx_on = 1'b0, c_srst = 1'b0, c_pkt_en = 1'b0;
    logic [1:0] c_ws = 2'd0;
    logic [15:0] c_pkt = 16'd0;
    logic c_ss_inact = 1'b1;
    logic tx_pop, rx_push, fifo_clr, tx_done, sclk, mosi, miso, ss_n, tx_valid;
    logic [31:0] rx_data, tx_data;
    logic [31:0] tx_words [8];
    int tx_idx = 0, tx_base = 0, tx_lim = 0, pops = 0, rx_cnt = 0;
    logic [31:0] rx_last = '0;
    int sl_cnt = 0, sclk_chg = 0, mosi_ones = 0, act_cnt = 0, bad_run = 0, run = 0;
    int exp_half = 2;
    logic sl_prev = 1'b0;
    logic [63:0] mosi_sh = '0;
    int nchk = 0, nbad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign tx_valid = (tx_idx < tx_lim);
    assign tx_data  = tx_words[3'(tx_idx - tx_base)];
    assign miso     = STREAM[63 - (sl_cnt % 64)];

    spi_pkt_master i_spi_pkt_master (
        .clk(clk), .rst_n(rst_n), .psr(c_psr), .sclk_en(c_sclk_en),
        .cpol(c_cpol), .cpha(c_cpha), .hs_en(c_hs), .rx_on(c_rx_on),
        .tx_on(c_tx_on), .soft_rst(c_srst), .word_sz(c_ws), .pkt_en(c_pkt_en),
        .pkt_cnt(c_pkt), .ss_inact(c_ss_inact), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_data(rx_data), .fifo_clr(fifo_clr), .tx_done(tx_done),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always @(posedge clk) begin
        if (tx_pop) begin tx_idx <= tx_idx + 1; pops <= pops + 1; end
        if (rx_push) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_data; end
    end

    // Slave model: streams MISO on leading edges, captures MOSI at the sample edge
    always @(sclk or ss_n) begin
        if (ss_n) sl_cnt = 0;
        else if (sclk !== sl_prev) begin
            sclk_chg++;
            if (sclk != c_cpol) sl_cnt++;
            if (c_cpha ? (sclk == c_cpol) : (sclk != c_cpol)) begin
                mosi_sh = {mosi_sh[62:0], mosi};
                if (mosi) mosi_ones++;
            end
        end
        sl_prev = sclk;
    end

    always @(negedge clk) begin
        if (!ss_n) begin
            if (sclk != c_cpol) run++;
            else if (run != 0) begin
                act_cnt++;
                if (run != exp_half) bad_run++;
                run = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int wsz2w(input logic [1:0] ws);
        return (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
    endfunction

    function automatic logic [31:0] exp_rx(input int w, input int off);
        logic [31:0] r = '0;
        for (int k = 0; k < w; k++) r = {r[30:0], STREAM[63 - (k + off)]};
        return r;
    endfunction

    task automatic wait_rx(input int target);
        for (int i = 0; i < 20000 && rx_cnt < target; i++) @(negedge clk);
    endtask

    task automatic wait_pops(input int target);
        for (int i = 0; i < 20000 && pops < target; i++) @(negedge clk);
    endtask

    task automatic load_words(input int n, input logic [31:0] first);
        for (int i = 0; i < n; i++) tx_words[i] = first + 32'(i) * 32'h1111;
        tx_base = tx_idx;
        tx_lim  = tx_idx + n;
    endtask

    task automatic run_row(input logic [44:0] v);
        int w, a0, b0, r0, off;
        logic [63:0] m;
        @(negedge clk);
        c_cpol = v[44]; c_cpha = v[43]; c_ws = v[42:41]; c_psr = v[40:33];
        c_hs = v[32]; c_tx_on = 1'b1; c_rx_on = 1'b1; c_pkt_en = 1'b0;
        exp_half = int'(v[40:33]) + 1;
        w = wsz2w(v[42:41]);
        m = (64'd1 << w) - 64'd1;
        off = (v[43] || v[32]) ? 1 : 0;
        @(negedge clk);
        chk(sclk == c_cpol, "R4 idle level", 64'(sclk), 64'(c_cpol));
        a0 = act_cnt; b0 = bad_run; r0 = rx_cnt;
        load_words(1, v[31:0]);
        c_ss_inact = 1'b0;
        wait_rx(r0 + 1);
        repeat (6) @(negedge clk);
        chk(rx_last == exp_rx(w, off), "R5/R6 rx word", 64'(rx_last), 64'(exp_rx(w, off)));
        chk((mosi_sh & m) == (64'(v[31:0]) & m), "R5 mosi word", mosi_sh & m, 64'(v[31:0]) & m);
        chk(act_cnt - a0 == w, "R4 edge count", 64'(act_cnt - a0), 64'(w));
        chk(bad_run == b0, "R2 half period", 64'(bad_run - b0), 64'd0);
        chk(tx_done == 1'b1, "R12 done after word", 64'(tx_done), 64'd1);
        c_ss_inact = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        int p0, r0, a0, o0, c0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ss_n == 1'b1, "R1 ss_n", 64'(ss_n), 64'd1);
        chk(sclk == 1'b0, "R1 sclk", 64'(sclk), 64'd0);
        chk(rx_push == 1'b0 && tx_pop == 1'b0, "R1 strobes", 64'({rx_push, tx_pop}), 64'd0);
        chk(tx_done == 1'b1, "R1 tx_done", 64'(tx_done), 64'd1);

        for (int i = 0; i < 7; i++) run_row(VEC[i]);

        // R9 / R8: receive-only packet run of 3 zero words
        @(negedge clk);
        c_cpol = 0; c_cpha = 0; c_ws = 0; c_psr = 1; c_hs = 0; exp_half = 2;
        c_tx_on = 0; c_rx_on = 1; c_pkt_en = 1; c_pkt = 16'd3;
        p0 = pops; r0 = rx_cnt; a0 = act_cnt; o0 = mosi_ones;
        c_ss_inact = 0;
        wait_rx(r0 + 3);
        repeat (60) @(negedge clk);
        chk(rx_cnt - r0 == 3, "R8 pkt words", 64'(rx_cnt - r0), 64'd3);
        chk(act_cnt - a0 == 24, "R8 pkt edges", 64'(act_cnt - a0), 64'd24);
        chk(pops == p0, "R9 no pops", 64'(pops - p0), 64'd0);
        chk(mosi_ones == o0, "R9 zero words", 64'(mosi_ones - o0), 64'd0);
        c_ss_inact = 1;

        // R8: packet limit with TX data, restart after select toggles
        @(negedge clk);
        c_tx_on = 1; c_pkt = 16'd2;
        p0 = pops; r0 = rx_cnt;
        load_words(4, 32'h0000_0031);
        @(negedge clk);
        chk(tx_done == 1'b0, "R12 pending words", 64'(tx_done), 64'd0);
        c_ss_inact = 0;
        wait_rx(r0 + 2);
        repeat (60) @(negedge clk);
        chk(pops - p0 == 2, "R8 limit pops", 64'(pops - p0), 64'd2);
        chk(rx_cnt - r0 == 2, "R8 limit words", 64'(rx_cnt - r0), 64'd2);
        c_ss_inact = 1;
        @(negedge clk);
        c_ss_inact = 0;
        wait_rx(r0 + 4);
        repeat (60) @(negedge clk);
        chk(pops - p0 == 4, "R8 restart pops", 64'(pops - p0), 64'd4);
        c_ss_inact = 1;
        @(negedge clk);
        tx_lim = tx_idx;

        // R10: no packet counter, TX only
        @(negedge clk);
        c_pkt_en = 0; c_rx_on = 0; c_tx_on = 1;
        p0 = pops; r0 = rx_cnt;
        load_words(3, 32'h0000_0077);
        c_ss_inact = 0;
        wait_pops(p0 + 3);
        repeat (60) @(negedge clk);
        chk(pops - p0 == 3, "R10 pops", 64'(pops - p0), 64'd3);
        chk(rx_cnt == r0, "R10 rx off", 64'(rx_cnt - r0), 64'd0);
        chk(tx_done == 1'b1, "R12 drained", 64'(tx_done), 64'd1);
        c_ss_inact = 1;

        // R3: clock disabled
        @(negedge clk);
        c_rx_on = 1; c_sclk_en = 0;
        p0 = pops; r0 = rx_cnt; c0 = sclk_chg;
        load_words(1, 32'h0000_00C9);
        c_ss_inact = 0;
        repeat (40) @(negedge clk);
        chk(sclk_chg == c0, "R3 no edges", 64'(sclk_chg - c0), 64'd0);
        chk(pops == p0, "R3 no start", 64'(pops - p0), 64'd0);
        c_sclk_en = 1;
        wait_rx(r0 + 1);
        repeat (4) @(negedge clk);
        chk(rx_cnt - r0 == 1, "R3 resumes", 64'(rx_cnt - r0), 64'd1);
        c_ss_inact = 1;

        // R7: abort by select
        @(negedge clk);
        c_ws = 2; c_psr = 3;
        r0 = rx_cnt;
        load_words(1, 32'hA5A5_0F0F);
        c_ss_inact = 0;
        repeat (30) @(negedge clk);
        c_ss_inact = 1;
        chk(ss_n == 1'b1, "R7 ss_n follows", 64'(ss_n), 64'd1);
        @(negedge clk);
        chk(sclk == c_cpol, "R7 sclk idle", 64'(sclk), 64'(c_cpol));
        repeat (80) @(negedge clk);
        chk(rx_cnt == r0, "R7 no push", 64'(rx_cnt - r0), 64'd0);

        // R11: software reset
        @(negedge clk);
        r0 = rx_cnt;
        load_words(1, 32'h5A5A_F0F0);
        c_ss_inact = 0;
        repeat (30) @(negedge clk);
        c_srst = 1;
        #1;
        chk(fifo_clr == 1'b1, "R11 flush", 64'(fifo_clr), 64'd1);
        @(negedge clk);
        chk(sclk == c_cpol, "R11 sclk idle", 64'(sclk), 64'(c_cpol));
        repeat (80) @(negedge clk);
        chk(rx_cnt == r0, "R11 no push", 64'(rx_cnt - r0), 64'd0);
        c_srst = 0;
        c_ss_inact = 1;
        @(negedge clk);
        chk(fifo_clr == 1'b0, "R11 flush release", 64'(fifo_clr), 64'd0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule